// File: doc/BRIEF.md
# Completion Queue with Selective Mispredict Flush

This block is an in-order completion queue for a dual-dispatch core. Dispatch writes up to two instructions per clock into consecutive slots. Each slot is named by an index, which the block returns on `disp_idx0` and `disp_idx1`. Execution units later report those indices as finished. The oldest finished entries leave the queue in program order, at most two per clock. Their tags appear on the retire lanes so that a write-back stage can commit the results to the architectural registers.

A branch entry can be reported as finished and mispredicted. When that happens, the queue keeps the branch and every entry older than it, and those entries go on to retire normally. Every entry younger than the branch is discarded. The cycle after the report is a flush cycle, during which dispatch is held off. At the end of the flush cycle the younger slots are freed and the tail moves to the slot just after the branch. A one-cycle resume pulse then tells the front end that dispatch from the corrected path may begin.

Top module: `cq_flush`

## Requirements
- R1: After reset the queue is empty: `disp_rdy` is 1, `ret_vld` is 00, `resume` is 0 and `disp_idx0` is 0.
- R2: An accepted lane 0 instruction occupies slot `disp_idx0`, and an accepted lane 1 instruction occupies slot `disp_idx1`, the next slot. Lane 1 is accepted only when lane 0 is also valid, so `disp_vld` = 10 dispatches nothing.
- R3: `disp_rdy` is 1 only when at least two of the six slots are free and no flush is pending. Dispatch requests made while `disp_rdy` is 0 are ignored.
- R4: A finish report that names an empty slot, or a slot younger than a pending flush branch, is ignored. It never causes that slot to retire.
- R5: `ret_vld[0]` is 1 when the oldest entry is finished, and `ret_vld[1]` is 1 only when the second oldest entry is finished as well. `ret_tag0` and `ret_tag1` carry their tags, and the entries leave the queue at that clock edge.
- R6: After a mispredict report on a branch entry, the next cycle is a flush cycle with `disp_rdy` at 0. At its end all entries younger than the branch are removed and the tail moves to the slot after the branch. The branch and the older entries stay and retire. During the flush cycle, retirement never passes the branch.
- R7: `resume` is 1 for exactly the one cycle that follows the flush cycle, and in that cycle `disp_rdy` is 1 again if there is room.
- R8: When both finish lanes report mispredicted branches in the same cycle, the flush uses the older branch by queue position.
- R9: A mispredict flag on a non-branch entry acts as a plain finish. It causes no flush and no resume pulse.
- R10: Slot indices wrap from 5 back to 0, both for allocation and for retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_vld | input | 2 | Dispatch lane valids (bit 0 = older lane) |
| disp_br | input | 2 | Dispatch lane is a branch |
| disp_tag0 | input | 8 | Tag of lane 0 instruction |
| disp_tag1 | input | 8 | Tag of lane 1 instruction |
| disp_rdy | output | 1 | Queue accepts dispatch this cycle |
| disp_idx0 | output | 3 | Slot given to lane 0 |
| disp_idx1 | output | 3 | Slot given to lane 1 |
| fin_vld | input | 2 | Finish report valids, one per execution lane |
| fin_idx0 | input | 3 | Slot reported by finish lane 0 |
| fin_idx1 | input | 3 | Slot reported by finish lane 1 |
| fin_mis | input | 2 | Finish lane reports a mispredicted branch |
| ret_vld | output | 2 | Retire lanes valid (bit 0 = oldest) |
| ret_tag0 | output | 8 | Tag of oldest retiring entry |
| ret_tag1 | output | 8 | Tag of second retiring entry |
| resume | output | 1 | One-cycle pulse: dispatch may restart on the corrected path |

## Verification
The assertions assume that every finish index is below the queue depth. They also assume that each dispatched entry is reported finished at most once, so that no second mispredict arrives for a branch that has already been flushed. The stimulus only ever names slots 0 to 5. It reports empty slots only on purpose, to exercise the ignore rule, and it raises mispredict flags only on entries that the scenario has just placed. Dispatch lanes are driven freely, including while `disp_rdy` is low and with lane 1 alone. This is because the block itself must filter those cases.

// File: rtl/cq_flush.sv
module cq_flush #(
  parameter int DEPTH = 6,
  parameter int TAGW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      disp_vld,
  input  logic [1:0]      disp_br,
  input  logic [TAGW-1:0] disp_tag0,
  input  logic [TAGW-1:0] disp_tag1,
  output logic            disp_rdy,
  output logic [$clog2(DEPTH)-1:0] disp_idx0,
  output logic [$clog2(DEPTH)-1:0] disp_idx1,
  input  logic [1:0]      fin_vld,
  input  logic [$clog2(DEPTH)-1:0] fin_idx0,
  input  logic [$clog2(DEPTH)-1:0] fin_idx1,
  input  logic [1:0]      fin_mis,
  output logic [1:0]      ret_vld,
  output logic [TAGW-1:0] ret_tag0,
  output logic [TAGW-1:0] ret_tag1,
  output logic            resume
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [IW:0]   DEP      = (IW+1)'(DEPTH);
  localparam logic [IW-1:0] LAST     = IW'(DEPTH - 1);
  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - 2);

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IW-1:0] age_of(input logic [IW-1:0] i, input logic [IW-1:0] h);
    logic [IW:0] d;
    d = {1'b0, i} + DEP - {1'b0, h};
    if (d >= DEP) d = d - DEP;
    return d[IW-1:0];
  endfunction

  logic [DEPTH-1:0] v, f, b, m, vn, fn, bn, mn;
  logic [TAGW-1:0]  tag [DEPTH];
  logic [IW-1:0]    head, tail, pbr, h1, pa, cand_i;
  logic [CW-1:0]    cnt;
  logic             pend, cand_v;
  logic             dacc0, dacc1, fok0, fok1, mk0, mk1;
  logic [1:0]       nret;

  assign h1       = nxt(head);
  assign pa       = age_of(pbr, head);
  assign disp_rdy = !pend && (cnt <= ROOM_MAX);
  assign dacc0    = disp_rdy && disp_vld[0];
  assign dacc1    = dacc0 && disp_vld[1];
  assign disp_idx0 = tail;
  assign disp_idx1 = nxt(tail);

  assign ret_vld[0] = v[head] && f[head];
  assign ret_vld[1] = ret_vld[0] && v[h1] && f[h1] && !(pend && pbr == head);
  assign nret       = {1'b0, ret_vld[0]} + {1'b0, ret_vld[1]};
  assign ret_tag0   = tag[head];
  assign ret_tag1   = tag[h1];

  assign fok0 = fin_vld[0] && v[fin_idx0] && !(pend && age_of(fin_idx0, head) > pa);
  assign fok1 = fin_vld[1] && v[fin_idx1] && !(pend && age_of(fin_idx1, head) > pa);
  assign mk0  = fok0 && fin_mis[0] && b[fin_idx0];
  assign mk1  = fok1 && fin_mis[1] && b[fin_idx1];
  assign cand_v = mk0 || mk1;
  assign cand_i = (mk0 && (!mk1 || age_of(fin_idx0, head) <= age_of(fin_idx1, head)))
                  ? fin_idx0 : fin_idx1;

  always_comb begin
    vn = v; fn = f; bn = b; mn = m;
    if (fok0) begin fn[fin_idx0] = 1'b1; mn[fin_idx0] = fin_mis[0] && b[fin_idx0]; end
    if (fok1) begin fn[fin_idx1] = 1'b1; mn[fin_idx1] = fin_mis[1] && b[fin_idx1]; end
    if (ret_vld[0]) vn[head] = 1'b0;
    if (ret_vld[1]) vn[h1]   = 1'b0;
    if (pend)
      for (int i = 0; i < DEPTH; i++)
        if (age_of(IW'(i), head) > pa) vn[i] = 1'b0;
    if (dacc0) begin
      vn[tail] = 1'b1; fn[tail] = 1'b0; bn[tail] = disp_br[0]; mn[tail] = 1'b0;
    end
    if (dacc1) begin
      vn[nxt(tail)] = 1'b1; fn[nxt(tail)] = 1'b0;
      bn[nxt(tail)] = disp_br[1]; mn[nxt(tail)] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (dacc0) tag[tail]      <= disp_tag0;
    if (dacc1) tag[nxt(tail)] <= disp_tag1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0; f <= '0; b <= '0; m <= '0;
      head <= '0; tail <= '0; cnt <= '0;
      pend <= 1'b0; pbr <= '0; resume <= 1'b0;
    end else begin
      v <= vn; f <= fn; b <= bn; m <= mn;
      head <= (nret == 2'd2) ? nxt(h1) : (nret == 2'd1) ? h1 : head;
      if (pend) begin
        tail <= nxt(pbr);
        cnt  <= CW'(pa) + CW'(1) - CW'(nret);
      end else begin
        tail <= dacc1 ? nxt(nxt(tail)) : dacc0 ? nxt(tail) : tail;
        cnt  <= cnt + CW'(dacc0) + CW'(dacc1) - CW'(nret);
      end
      pend   <= cand_v;
      if (cand_v) pbr <= cand_i;
      resume <= pend && !cand_v;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'($countones(v)) == cnt); // R3
  AST_DISP_FREE0: assert property (@(posedge clk) disable iff (!rst_n)
    dacc0 |-> !v[tail]); // R2
  AST_DISP_FREE1: assert property (@(posedge clk) disable iff (!rst_n)
    dacc1 |-> !v[nxt(tail)]); // R2
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> tail == nxt($past(pbr))); // R6
  AST_RESUME_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(pend)); // R7
  AST_RESUME_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R7
endmodule

// File: tb/sim_cq_flush.sv
`timescale 1ns/1ps
module sim_cq_flush;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] disp_vld = '0, disp_br = '0, fin_vld = '0, fin_mis = '0;
  logic [7:0] disp_tag0 = '0, disp_tag1 = '0;
  logic [2:0] fin_idx0 = '0, fin_idx1 = '0;
  logic disp_rdy, resume;
  logic [2:0] disp_idx0, disp_idx1;
  logic [1:0] ret_vld;
  logic [7:0] ret_tag0, ret_tag1;
  int ntest = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cq_flush u0 (.clk, .rst_n, .disp_vld, .disp_br, .disp_tag0, .disp_tag1, .disp_rdy,
               .disp_idx0, .disp_idx1, .fin_vld, .fin_idx0, .fin_idx1, .fin_mis,
               .ret_vld, .ret_tag0, .ret_tag1, .resume);

  // row: dv[15:14] fv[13:12] fi0[11:9] fi1[8:6] | exp rdy[5] ret[4:3] idx0[2:0]
  localparam logic [15:0] VEC [14] = '{
    {2'b11, 2'b00, 3'd0, 3'd0, 1'b1, 2'b00, 3'd0},
    {2'b11, 2'b00, 3'd0, 3'd0, 1'b1, 2'b00, 3'd2},
    {2'b11, 2'b00, 3'd0, 3'd0, 1'b1, 2'b00, 3'd4},
    {2'b11, 2'b01, 3'd1, 3'd0, 1'b0, 2'b00, 3'd0},
    {2'b00, 2'b01, 3'd0, 3'd0, 1'b0, 2'b00, 3'd0},
    {2'b00, 2'b00, 3'd0, 3'd0, 1'b0, 2'b11, 3'd0},
    {2'b01, 2'b01, 3'd3, 3'd0, 1'b1, 2'b00, 3'd0},
    {2'b00, 2'b01, 3'd2, 3'd0, 1'b0, 2'b00, 3'd1},
    {2'b00, 2'b11, 3'd5, 3'd4, 1'b0, 2'b11, 3'd1},
    {2'b00, 2'b01, 3'd0, 3'd0, 1'b1, 2'b11, 3'd1},
    {2'b00, 2'b00, 3'd0, 3'd0, 1'b1, 2'b01, 3'd1},
    {2'b00, 2'b01, 3'd3, 3'd0, 1'b1, 2'b00, 3'd1},
    {2'b11, 2'b00, 3'd0, 3'd0, 1'b1, 2'b00, 3'd1},
    {2'b00, 2'b00, 3'd0, 3'd0, 1'b1, 2'b00, 3'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] dv, input logic [1:0] dbr, input logic [7:0] t0,
                       input logic [7:0] t1, input logic [1:0] fv, input logic [2:0] i0,
                       input logic [2:0] i1, input logic [1:0] fm);
    disp_vld = dv; disp_br = dbr; disp_tag0 = t0; disp_tag1 = t1;
    fin_vld = fv; fin_idx0 = i0; fin_idx1 = i1; fin_mis = fm;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b00, 3'd0, 3'd0, 2'b00);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b00, 3'd0, 3'd0, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 rdy", disp_rdy, 1); chk("R1 ret", ret_vld, 0);
    chk("R1 resume", resume, 0); chk("R1 idx0", disp_idx0, 0);

    // table walk: R2, R3, R4, R5, R10
    for (int r = 0; r < 14; r++) begin
      logic [15:0] row;
      row = VEC[r];
      chk("R3 rdy", disp_rdy, row[5]);
      chk("R5 ret_vld", ret_vld, row[4:3]);
      chk("R2/R10 idx0", disp_idx0, row[2:0]);
      drive(row[15:14], 2'b00, 8'h40 + 8'(2*r), 8'h41 + 8'(2*r),
            row[13:12], row[11:9], row[8:6], 2'b00);
      tick();
    end

    // R1 reset during activity
    drive(2'b11, 2'b00, 8'h1, 8'h2, 2'b00, 3'd0, 3'd0, 2'b00);
    tick();
    do_reset();
    chk("R1 rdy", disp_rdy, 1); chk("R1 ret", ret_vld, 0);
    chk("R1 resume", resume, 0); chk("R1 idx0", disp_idx0, 0);

    // R2 lane 1 alone is not accepted
    drive(2'b10, 2'b00, 8'h9, 8'h9, 2'b00, 3'd0, 3'd0, 2'b00);
    tick();
    chk("R2 lane1 alone", disp_idx0, 0);

    // R6/R7 selective flush, branch at slot 2 of a full queue
    do_reset();
    drive(2'b11, 2'b00, 8'h20, 8'h21, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b11, 2'b01, 8'h22, 8'h23, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b11, 2'b00, 8'h24, 8'h25, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b01, 3'd2, 3'd0, 2'b01); tick();
    chk("R6 rdy in flush", disp_rdy, 0);
    chk("R7 no early resume", resume, 0);
    chk("R6 ret in flush", ret_vld, 0);
    tick();
    chk("R7 resume", resume, 1);
    chk("R7 rdy back", disp_rdy, 1);
    chk("R6 tail after branch", disp_idx0, 3);
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b11, 3'd0, 3'd1, 2'b00); tick();
    chk("R7 resume single", resume, 0);
    chk("R5 ret both", ret_vld, 2'b11);
    chk("R5 tag0", ret_tag0, 8'h20);
    chk("R5 tag1", ret_tag1, 8'h21);
    tick();
    chk("R6 branch retires", ret_vld, 2'b01);
    chk("R6 branch tag", ret_tag0, 8'h22);
    tick();
    chk("R6 younger gone", ret_vld, 0);
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b01, 3'd3, 3'd0, 2'b00); tick();
    chk("R4 empty report", ret_vld, 0);
    chk("R6 idx after drain", disp_idx0, 3);

    // R8 oldest mispredict wins; retire stops at branch during flush
    do_reset();
    drive(2'b11, 2'b11, 8'h30, 8'h31, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b11, 2'b00, 8'h32, 8'h33, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b11, 3'd1, 3'd0, 2'b11); tick();
    chk("R6 retire bounded", ret_vld, 2'b01);
    chk("R8 oldest tag", ret_tag0, 8'h30);
    chk("R6 rdy low", disp_rdy, 0);
    tick();
    chk("R8 resume", resume, 1);
    chk("R8 tail after oldest", disp_idx0, 1);
    chk("R8 younger branch gone", ret_vld, 0);

    // R9 mispredict flag on a non-branch entry
    do_reset();
    drive(2'b11, 2'b00, 8'h50, 8'h51, 2'b00, 3'd0, 3'd0, 2'b00); tick();
    drive(2'b00, 2'b00, 8'h0, 8'h0, 2'b01, 3'd0, 3'd0, 2'b01); tick();
    chk("R9 rdy", disp_rdy, 1);
    chk("R9 ret", ret_vld, 2'b01);
    tick();
    chk("R9 no resume", resume, 0);
    chk("R9 idx", disp_idx0, 2);

    done = 1;
    summary();
    $finish;
  end
endmodule